// File: doc/BRIEF.md
# Self-Description Parameter Read Responder

This block is the flash-side responder for the command that lets a host discover a serial NOR device's capabilities. It watches a mode-0 SPI bus while chip select is low. If the first byte is the parameter-read opcode, it takes a 24-bit offset into a small parameter space that is separate from the main array. After that offset it lets one turnaround byte pass. It then streams parameter bytes on MISO from the addressed offset onward, one byte after another, until chip select rises. It ignores any other opcode for the rest of that transaction and never drives MISO for it.

The bus pins are sampled by the block's own system clock through two-stage synchronisers, and SCK edges are found from the synchronised copy. The system clock must therefore run at least about eight times faster than SCK. The parameter contents come from parameters. A fixed signature and version header sits at offset 0. A single parameter header at offset 8 points to a basic parameter table, which by default holds 16 dwords at offset 0x30. MISO is given as a data bit plus an output-enable. The pad or the surrounding logic turns the pair into a three-state pin.

Top module: `sfdp_responder`

## Requirements
- R1: Only the first byte 0x5A starts a read. With any other first byte, the rest of that chip-select period has no effect and `miso_oe_o` stays 0 for all of it.
- R2: Bits are taken from MOSI on rising SCK, MSB first. After the opcode, three bytes form the 24-bit start offset, most significant byte first.
- R3: Exactly 8 SCK cycles of turnaround follow the last address bit, and MOSI is ignored during them and during the data phase. The MSB of the first data byte is on MISO before the first rising SCK edge after those 8 cycles.
- R4: Offsets 0..7 hold 0x53, 0x46, 0x44, 0x50, 0x06, 0x01, then the header-count parameter (default 0x01), then 0xFF.
- R5: Offsets 8..15 hold 0xFF (table ID), 0x00 (minor revision), the table length in dwords (default 0x10), 0x01 (major revision), the table pointer in little-endian order (default 0x30, 0x00, 0x00), then 0xFF.
- R6: From the table pointer onward, byte k of the table is byte k mod 4 of dword k/4 of the table parameter, least significant byte first. Every other offset reads 0xFF, both the unused offsets below the table and all offsets past its end.
- R7: Each later data byte comes from the next offset. The offset wraps from 0xFFFFFF to 0x000000.
- R8: A chip-select rise at any bit position returns the block to idle and drops `miso_oe_o` within 4 system clocks. The next transaction then decodes from its first bit.
- R9: MISO changes only after a falling SCK edge in the data phase, MSB first. `miso_oe_o` is 1 only in the data phase.
- R10: After reset, `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | SPI clock from the host, idles low |
| cs_n_i | input | 1 | Chip select from the host, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Drive enable for MISO; 0 means released |

## Verification
A behavioural model in the bench predicts each byte from the offset arithmetic alone. It is compared with reads that start at offset 0, at an odd offset inside the header, at the table pointer and running past the table end, and just below the top of the 24-bit space. Together these separate errors in the header bytes, in the dword byte order, in the end-of-table fill and in the wrap. Toggling MOSI during turnaround and data shows whether the block listens when it should not, and a one-clock shift in the turnaround length misaligns every byte. Transactions broken off mid-address and mid-data, each followed by a fresh read, show whether a chip-select rise fully clears the decode. A foreign opcode with output-enable watched on every clock shows whether the command is rejected.

// File: rtl/sfdp_pkg.sv
// Shared definitions for the parameter read responder.
// Assumes a single opcode and a 24-bit parameter address space.
package sfdp_pkg;
    localparam int          ADDR_W    = 24;
    localparam int          BYTE_W    = 8;
    localparam int          BIT_CNT_W = $clog2(BYTE_W);
    localparam int          ADDR_BYTES = ADDR_W / BYTE_W;
    localparam logic [7:0]  OPC_PARAM_READ = 8'h5A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rsp_state_t;
endpackage

// File: rtl/sfdp_sync.sv
// Multi-bit, multi-stage flop synchroniser for asynchronous bus pins.
// Assumes every bit is an independent level; no bus coherency is claimed.
module sfdp_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop rank of the chain; rank 0 takes the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sfdp_rom.sv
// Read-only parameter space: signature header, one parameter header and a
// basic table. The table is a parameter; header fields derive from it.
// Assumes the table fits below DEPTH; all other offsets read 0xFF.
module sfdp_rom
    import sfdp_pkg::*;
#(
    parameter int          DEPTH        = 112,
    parameter int          TABLE_BASE   = 'h30,
    parameter int          TABLE_DWORDS = 16,
    parameter logic [7:0]  HDR_COUNT    = 8'h01,
    parameter logic [TABLE_DWORDS*32-1:0] BASIC_TABLE = {
        32'h000008F0, 32'hFF829F19, 32'h5CD5BDF7, 32'h757A757A,
        32'h38651AD4, 32'h82A804C4, 32'h00C3B24A, 32'hFF00D810,
        32'h520F200C, 32'hEB44FFFF, 32'hFF00FFFF, 32'hFFFFFFFE,
        32'hBB043B08, 32'h6B08EB44, 32'h0FFFFFFF, 32'hFFF120E5 }
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);
    localparam int TABLE_END = TABLE_BASE + TABLE_DWORDS * 4;
    localparam logic [23:0] PTR = TABLE_BASE[23:0];

    logic [7:0] hdr_byte;
    logic       in_hdr;
    logic       in_table;
    int         tidx;

    // Fixed header and parameter-header bytes at offsets 0..15.
    always_comb begin
        in_hdr   = 1'b1;
        hdr_byte = 8'hFF;
        case (addr_i)
            24'd0:   hdr_byte = 8'h53;
            24'd1:   hdr_byte = 8'h46;
            24'd2:   hdr_byte = 8'h44;
            24'd3:   hdr_byte = 8'h50;
            24'd4:   hdr_byte = 8'h06;
            24'd5:   hdr_byte = 8'h01;
            24'd6:   hdr_byte = HDR_COUNT;
            24'd7:   hdr_byte = 8'hFF;
            24'd8:   hdr_byte = 8'hFF;
            24'd9:   hdr_byte = 8'h00;
            24'd10:  hdr_byte = TABLE_DWORDS[7:0];
            24'd11:  hdr_byte = 8'h01;
            24'd12:  hdr_byte = PTR[7:0];
            24'd13:  hdr_byte = PTR[15:8];
            24'd14:  hdr_byte = PTR[23:16];
            24'd15:  hdr_byte = 8'hFF;
            default: in_hdr = 1'b0;
        endcase
    end

    // Table window decode and final byte selection.
    always_comb begin
        tidx     = int'({8'd0, addr_i}) - TABLE_BASE;
        in_table = (int'({8'd0, addr_i}) >= TABLE_BASE) &&
                   (int'({8'd0, addr_i}) <  TABLE_END) &&
                   (int'({8'd0, addr_i}) <  DEPTH);
        if (in_hdr) begin
            data_o = hdr_byte;
        end else if (in_table) begin
            data_o = BASIC_TABLE[tidx*8 +: 8];
        end else begin
            data_o = 8'hFF;
        end
    end
endmodule

// File: rtl/sfdp_engine.sv
// Bus decode engine: finds SCK edges in the synchronised pins, shifts in
// opcode and offset on rising edges, counts the turnaround byte and shifts
// parameter bytes out on falling edges with auto-increment.
// Assumes system clock is well above 4x SCK and CS# setup exceeds 2 clocks.
module sfdp_engine
    import sfdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [7:0]        rom_data_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    rsp_state_t           state;
    logic                 sck_d;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [1:0]           byte_cnt;
    logic [6:0]           rx_sh;
    logic [ADDR_W-1:0]    addr;
    logic [6:0]           tx_sh;
    logic [BIT_CNT_W-1:0] out_cnt;
    logic                 miso_q;
    logic                 sck_rise;
    logic                 sck_fall;
    logic [7:0]           rx_byte;
    logic                 byte_done;

    // Edge detect and assembled receive byte.
    always_comb begin
        sck_rise  = sck_s & ~sck_d;
        sck_fall  = ~sck_s & sck_d;
        rx_byte   = {rx_sh, mosi_s};
        byte_done = sck_rise && (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
    end

    // Previous SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Transaction state machine with receive and transmit shifters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_sh    <= '0;
            addr     <= '0;
            tx_sh    <= '1;
            out_cnt  <= '0;
            miso_q   <= 1'b1;
        end else if (cs_n_s) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            out_cnt  <= '0;
            miso_q   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: state <= ST_CMD;
                ST_CMD, ST_ADDR, ST_DUMMY: begin
                    if (sck_rise) begin
                        rx_sh   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        if (state == ST_CMD) begin
                            state <= (rx_byte == OPC_PARAM_READ) ? ST_ADDR : ST_IGNORE;
                        end else if (state == ST_ADDR) begin
                            addr     <= {addr[ADDR_W-9:0], rx_byte};
                            byte_cnt <= byte_cnt + 1'b1;
                            if (byte_cnt == 2'(ADDR_BYTES - 1)) state <= ST_DUMMY;
                        end else begin
                            state   <= ST_DATA;
                            out_cnt <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_fall) begin
                        out_cnt <= out_cnt + 1'b1;
                        if (out_cnt == '0) begin
                            miso_q <= rom_data_i[7];
                            tx_sh  <= rom_data_i[6:0];
                            addr   <= addr + 1'b1;
                        end else begin
                            miso_q <= tx_sh[6];
                            tx_sh  <= {tx_sh[5:0], 1'b1};
                        end
                    end
                end
                default: state <= ST_IGNORE;
            endcase
        end
    end

    assign rom_addr_o = addr;
    assign miso_o     = miso_q;
    assign miso_oe_o  = (state == ST_DATA);

    // R8: a synchronised CS# high releases MISO on the next clock.
    p_release_on_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso_oe_o);

    // R9: MISO only moves on a data-phase falling edge (or CS# release).
    p_miso_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !(sck_fall && state == ST_DATA)) |=> $stable(miso_o));

    // R1: a rejected command stays rejected until CS# rises.
    p_reject_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> (state == ST_IGNORE || state == ST_IDLE));

    // R3: turnaround is left only at the eighth rising edge.
    p_dummy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY && !cs_n_s && !byte_done) |=> (state == ST_DUMMY));

    // R7: each new byte load advances the offset by one.
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !cs_n_s && sck_fall && out_cnt == '0)
        |=> (rom_addr_o == $past(rom_addr_o) + 1'b1));
endmodule

// File: rtl/sfdp_responder.sv
// Top of the parameter read responder: pin synchronisers, decode engine and
// parameter space. MISO leaves as data plus drive enable.
// Assumes mode-0 SPI and a system clock at least ~8x SCK.
module sfdp_responder #(
    parameter int          DEPTH        = 112,
    parameter int          TABLE_BASE   = 'h30,
    parameter int          TABLE_DWORDS = 16,
    parameter logic [7:0]  HDR_COUNT    = 8'h01,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o
);
    import sfdp_pkg::*;

    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_data;

    sfdp_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({mosi_i, cs_n_i, sck_i}),
        .q_o  (pins_s)
    );

    sfdp_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[0]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[2]),
        .rom_data_i(rom_data),
        .rom_addr_o(rom_addr),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe_o)
    );

    sfdp_rom #(
        .DEPTH       (DEPTH),
        .TABLE_BASE  (TABLE_BASE),
        .TABLE_DWORDS(TABLE_DWORDS),
        .HDR_COUNT   (HDR_COUNT)
    ) u_rom (
        .addr_i(rom_addr),
        .data_o(rom_data)
    );
endmodule

// File: tb/sfdp_responder_tb.sv
// Bench: host-side SPI master in tasks, behavioural byte model, per-clock
// watch of the drive enable.
module sfdp_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic miso_oe;

    int  checks = 0;
    int  errors = 0;
    bit  quiet  = 1'b0;
    bit  done   = 1'b0;
    int  cs_hi_cnt = 0;

    logic [31:0] tbl [16] = '{
        32'hFFF120E5, 32'h0FFFFFFF, 32'h6B08EB44, 32'hBB043B08,
        32'hFFFFFFFE, 32'hFF00FFFF, 32'hEB44FFFF, 32'h520F200C,
        32'hFF00D810, 32'h00C3B24A, 32'h82A804C4, 32'h38651AD4,
        32'h757A757A, 32'h5CD5BDF7, 32'hFF829F19, 32'h000008F0 };

    sfdp_responder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck),
        .cs_n_i   (cs_n),
        .mosi_i   (mosi),
        .miso_o   (miso),
        .miso_oe_o(miso_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model of the parameter space (R4, R5, R6).
    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        logic [7:0] hdr [16] = '{8'h53, 8'h46, 8'h44, 8'h50, 8'h06, 8'h01,
                                 8'h01, 8'hFF, 8'hFF, 8'h00, 8'h10, 8'h01,
                                 8'h30, 8'h00, 8'h00, 8'hFF};
        int k;
        if (a < 24'd16) return hdr[a[3:0]];
        if (a >= 24'h30 && a < 24'h70) begin
            k = int'(a) - 'h30;
            return tbl[k/4][(k%4)*8 +: 8];
        end
        return 8'hFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the drive enable against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
            if (cs_hi_cnt >= 4)
                check(miso_oe == 1'b0, "R8 released while deselected", miso_oe, 0);
            if (quiet)
                check(miso_oe == 1'b0, "R1 foreign opcode drive", miso_oe, 0);
        end
    end

    // One SCK cycle: drive MOSI, sample MISO just before the rising edge.
    task automatic bit_cyc(input logic b, output logic r, output logic oe);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r  = miso;
        oe = miso_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic cs_low;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_high;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic r, oe;
        for (int i = 7; i >= 0; i--) bit_cyc(v[i], r, oe);
    endtask

    // Full read transaction; compares n streamed bytes to the model.
    task automatic xfer(input logic [7:0] op, input logic [23:0] a,
                        input int n, input string req);
        logic r, oe;
        logic [7:0] got, exp;
        logic [23:0] cur;
        cs_low();
        send_byte(op);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        for (int i = 0; i < 8; i++) bit_cyc(i[0], r, oe);   // turnaround, MOSI toggles (R3)
        cur = a;
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int i = 7; i >= 0; i--) begin
                bit_cyc(~i[0] ^ k[0], r, oe);                // MOSI noise in data phase (R3)
                got[i] = r;
                if (op == 8'h5A)
                    check(oe == 1'b1, "R9 drive enable in data phase", oe, 1);
            end
            exp = exp_byte(cur);
            if (op == 8'h5A)
                check(got == exp, req, got, exp);
            cur = cur + 24'd1;
        end
        cs_high();
    endtask

    // Transaction broken off after nbits clocks.
    task automatic abort_after(input int nbits);
        logic r, oe;
        logic [39:0] pat = {8'h5A, 24'h000004, 8'hA5};
        cs_low();
        for (int i = 0; i < nbits; i++) bit_cyc(pat[39 - (i % 40)], r, oe);
        cs_high();
        check(miso_oe == 1'b0, "R8 enable after abort", miso_oe, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b0, "R10 reset enable", miso_oe, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(miso_oe == 1'b0, "R10 enable after reset", miso_oe, 0);
        // R4 R5: header and parameter header from offset 0.
        xfer(8'h5A, 24'h000000, 16, "R4/R5 header stream");
        // R2 R6: table from its pointer, then past its end.
        xfer(8'h5A, 24'h000030, 68, "R6 table and end fill");
        // R2: odd start offset inside the header.
        xfer(8'h5A, 24'h00000A, 5, "R2 odd offset start");
        // R6: unused gap below the table.
        xfer(8'h5A, 24'h00002E, 4, "R6 gap then table");
        // R7: wrap at the top of the offset space.
        xfer(8'h5A, 24'hFFFFFE, 4, "R7 offset wrap");
        // R1: foreign opcode, drive enable watched each clock.
        quiet = 1'b1;
        xfer(8'h03, 24'h000000, 4, "R1 foreign opcode");
        quiet = 1'b0;
        xfer(8'h5A, 24'h000004, 2, "R1 read after rejection");
        // R8: abort mid-address and mid-data, then fresh reads.
        abort_after(19);
        xfer(8'h5A, 24'h000001, 3, "R8 read after address abort");
        abort_after(40 + 8 + 11);
        xfer(8'h5A, 24'h000004, 2, "R8 read after data abort");
        abort_after(3);
        xfer(8'h5A, 24'h000038, 4, "R8 read after opcode abort");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule